// File: doc/BRIEF.md
# CAN Transmit Queue Scheduler

This block sits between a host that queues outgoing CAN messages and the engine that puts one frame at a time on the bus. It keeps up to eight pending messages in arrival order. It moves the oldest one into a single transmit buffer when sending is allowed, and it decides what happens after each bus outcome. The message is treated as an opaque word. Framing, bit stuffing and the physical layer live in the bus engine.

Sending runs in one of two ways. It runs continuously while either the external enable pin or the enable control bit is high. It can also run for exactly one message through a self-clearing single-send request. After a lost arbitration or a bus error the buffered message is retried in place, unless one-shot mode is set, in which case it is discarded. A successful frame frees the buffer and produces a push request toward a transmit history queue. An abort frees the buffer at once. Bus errors and queue overflows raise sticky flags, and these flags drive a level interrupt through per-flag enables.

Top module: `can_txq_sched`

## Requirements
- R1: The queue holds at most DEPTH (8) messages and releases them in arrival order. `q_count_o` gives the number held. A `q_clear_i` pulse empties the queue at the next edge.
- R2: A push while the queue is full is dropped, and `q_full_o` is high whenever the count equals DEPTH. The dropped push sets the sticky `ovf_o` at the next edge. `ovf_o` is cleared by an `ovf_clr_i` pulse, and a new overflow in the same cycle wins over the clear.
- R3: When the buffer is empty and the queue is not, the head message is moved into the buffer at the next edge if `txen_pin_i` OR `txen_bit_i` is high. `buf_valid_o` then rises and `buf_msg_o` shows that message.
- R4: A pulse on `one_set_i` sets `one_pend_o`. While both enables are low, this request moves exactly one message into the buffer. `one_pend_o` clears at the edge where that message leaves the buffer, and no second message is loaded.
- R5: When both enables are low and no single-send request is pending, no message is loaded. Dropping the enables while a message is buffered lets that message finish, and no further queued message is started.
- R6: On a lost-arbitration outcome with `one_shot_i` low, the message stays in the buffer unchanged for a retry. With `one_shot_i` high it is discarded, and the next queued message loads one cycle later if sending is allowed.
- R7: A bus-error outcome sets the sticky `buserr_o` at the next edge. `buserr_clr_i` clears it, and a new error in the same cycle wins over the clear. The error follows the same retry/discard rule as R6. `irq_o` equals (`buserr_o` AND `err_ie_i`) OR (`ovf_o` AND `ovf_ie_i`).
- R8: A success outcome raises `hist_push_o` in the same cycle, with `hist_msg_o` equal to the buffered message, and frees the buffer at the next edge. Success takes priority over a simultaneous fail outcome.
- R9: An abort while a message is buffered raises `bus_abort_o` in the same cycle and frees the buffer at the next edge. An abort overrides any simultaneous outcome, so no history push and no error flag result.
- R10: A clear in the same cycle as a push drops the push without setting `ovf_o`. A clear in the same cycle as a possible load suppresses the load.
- R11: Outcome pulses and abort while the buffer is empty have no effect on any output or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Queue one message |
| push_msg_i | input | MSG_W (32) | Message to queue |
| q_clear_i | input | 1 | Empty the queue |
| txen_pin_i | input | 1 | External continuous-send enable |
| txen_bit_i | input | 1 | Control-bit continuous-send enable |
| one_set_i | input | 1 | Request a single-message send |
| one_shot_i | input | 1 | Discard instead of retry after a failure |
| abort_i | input | 1 | Abort the buffered transmission |
| bus_ok_i | input | 1 | Bus engine: frame acknowledged |
| bus_lost_i | input | 1 | Bus engine: arbitration lost |
| bus_err_i | input | 1 | Bus engine: frame error |
| err_ie_i | input | 1 | Bus-error interrupt enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| buserr_clr_i | input | 1 | Clear bus-error flag |
| ovf_clr_i | input | 1 | Clear overflow flag |
| q_count_o | output | CNT_W (4) | Messages held in the queue |
| q_full_o | output | 1 | Queue full |
| buf_valid_o | output | 1 | Transmit buffer holds a message (request to bus engine) |
| buf_msg_o | output | MSG_W (32) | Buffered message |
| bus_abort_o | output | 1 | Abort strobe to bus engine |
| hist_push_o | output | 1 | Push request to history queue |
| hist_msg_o | output | MSG_W (32) | Message for history entry |
| one_pend_o | output | 1 | Single-send request pending |
| buserr_o | output | 1 | Sticky bus-error flag |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Level interrupt |

## Verification
Two events can collide in the same cycle. An abort can arrive in the cycle the bus engine reports success, and a queue clear can coincide with a push or with a pending load. The bench drives such pairs together in one cycle. It judges the result from the history strobe, `buf_valid_o` one edge later, `q_count_o` and `ovf_o`. In each case the reference model's priority order must match: abort over success, and clear over both push and load.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;
  localparam int NFLAGS     = 2;
  localparam int FLAG_BUSERR = 0;
  localparam int FLAG_OVF    = 1;
endpackage

// File: rtl/can_txq_fifo.sv
module can_txq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  input  logic                         clear_i,
  output logic [W-1:0]                 head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic                         ovf_evt_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign push_ok   = push_i & ~clear_i & ~full_o;
  assign pop_ok    = pop_i & ~clear_i & ~empty_o;
  assign ovf_evt_o = push_i & ~clear_i & full_o;
  assign head_o    = mem[rd_q];
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/can_txq_buf.sv
module can_txq_buf #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         one_set_i,
  input  logic         one_shot_i,
  input  logic         q_empty_i,
  input  logic [W-1:0] q_head_i,
  input  logic         clear_i,
  input  logic         abort_i,
  input  logic         ok_i,
  input  logic         lost_i,
  input  logic         err_i,
  output logic         pop_o,
  output logic         valid_o,
  output logic [W-1:0] msg_o,
  output logic         hist_push_o,
  output logic         abort_o,
  output logic         one_pend_o,
  output logic         err_evt_o
);
  logic         valid_q, single_q, one_q;
  logic [W-1:0] msg_q;
  logic         load, abort_hit, ok_hit, fail_hit, free;

  assign load      = ~valid_q & ~q_empty_i & (en_i | one_q) & ~clear_i;
  assign abort_hit = abort_i & valid_q;
  assign ok_hit    = ok_i & valid_q & ~abort_i;
  assign fail_hit  = (lost_i | err_i) & valid_q & ~abort_i & ~ok_i;
  assign free      = abort_hit | ok_hit | (fail_hit & one_shot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      single_q <= 1'b0;
      msg_q    <= '0;
    end else if (load) begin
      valid_q  <= 1'b1;
      single_q <= ~en_i;
      msg_q    <= q_head_i;
    end else if (free) begin
      valid_q  <= 1'b0;
    end
  end

  // single-send request self-clears when its own message leaves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 one_q <= 1'b0;
    else if (one_set_i)          one_q <= 1'b1;
    else if (free && single_q)   one_q <= 1'b0;
  end

  assign pop_o       = load;
  assign valid_o     = valid_q;
  assign msg_o       = msg_q;
  assign hist_push_o = ok_hit;
  assign abort_o     = abort_hit;
  assign one_pend_o  = one_q;
  assign err_evt_o   = fail_hit & err_i;
endmodule

// File: rtl/can_txq_flags.sv
module can_txq_flags
  import can_txq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFLAGS-1:0] set_i,
  input  logic [NFLAGS-1:0] clr_i,
  input  logic [NFLAGS-1:0] ie_i,
  output logic [NFLAGS-1:0] flag_o,
  output logic              irq_o
);
  logic [NFLAGS-1:0] flag_q;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (set_i[g])  flag_q[g] <= 1'b1;
      else if (clr_i[g])  flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ie_i);
endmodule

// File: rtl/can_txq_sched.sv
module can_txq_sched
  import can_txq_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int MSG_W = 32,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [MSG_W-1:0] push_msg_i,
  input  logic             q_clear_i,
  input  logic             txen_pin_i,
  input  logic             txen_bit_i,
  input  logic             one_set_i,
  input  logic             one_shot_i,
  input  logic             abort_i,
  input  logic             bus_ok_i,
  input  logic             bus_lost_i,
  input  logic             bus_err_i,
  input  logic             err_ie_i,
  input  logic             ovf_ie_i,
  input  logic             buserr_clr_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] q_count_o,
  output logic             q_full_o,
  output logic             buf_valid_o,
  output logic [MSG_W-1:0] buf_msg_o,
  output logic             bus_abort_o,
  output logic             hist_push_o,
  output logic [MSG_W-1:0] hist_msg_o,
  output logic             one_pend_o,
  output logic             buserr_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic [MSG_W-1:0]  q_head;
  logic              q_empty, q_pop, ovf_evt, err_evt;
  logic [NFLAGS-1:0] fl_set, fl_clr, fl_ie, fl_q;

  can_txq_fifo #(.DEPTH(DEPTH), .W(MSG_W)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .din_i     (push_msg_i),
    .pop_i     (q_pop),
    .clear_i   (q_clear_i),
    .head_o    (q_head),
    .count_o   (q_count_o),
    .empty_o   (q_empty),
    .full_o    (q_full_o),
    .ovf_evt_o (ovf_evt)
  );

  can_txq_buf #(.W(MSG_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (txen_pin_i | txen_bit_i),
    .one_set_i   (one_set_i),
    .one_shot_i  (one_shot_i),
    .q_empty_i   (q_empty),
    .q_head_i    (q_head),
    .clear_i     (q_clear_i),
    .abort_i     (abort_i),
    .ok_i        (bus_ok_i),
    .lost_i      (bus_lost_i),
    .err_i       (bus_err_i),
    .pop_o       (q_pop),
    .valid_o     (buf_valid_o),
    .msg_o       (buf_msg_o),
    .hist_push_o (hist_push_o),
    .abort_o     (bus_abort_o),
    .one_pend_o  (one_pend_o),
    .err_evt_o   (err_evt)
  );

  always_comb begin
    fl_set = '0;
    fl_clr = '0;
    fl_ie  = '0;
    fl_set[FLAG_BUSERR] = err_evt;
    fl_set[FLAG_OVF]    = ovf_evt;
    fl_clr[FLAG_BUSERR] = buserr_clr_i;
    fl_clr[FLAG_OVF]    = ovf_clr_i;
    fl_ie[FLAG_BUSERR]  = err_ie_i;
    fl_ie[FLAG_OVF]     = ovf_ie_i;
  end

  can_txq_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fl_set),
    .clr_i  (fl_clr),
    .ie_i   (fl_ie),
    .flag_o (fl_q),
    .irq_o  (irq_o)
  );

  assign buserr_o   = fl_q[FLAG_BUSERR];
  assign ovf_o      = fl_q[FLAG_OVF];
  assign hist_msg_o = buf_msg_o;
endmodule

// File: rtl/can_txq_sched_chk.sv
module can_txq_sched_chk #(
  parameter  int DEPTH = 8,
  parameter  int MSG_W = 32,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             q_clear_i,
  input logic             txen_pin_i,
  input logic             txen_bit_i,
  input logic             one_shot_i,
  input logic             abort_i,
  input logic             bus_ok_i,
  input logic             bus_lost_i,
  input logic             bus_err_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] q_count_o,
  input logic             q_full_o,
  input logic             buf_valid_o,
  input logic [MSG_W-1:0] buf_msg_o,
  input logic             bus_abort_o,
  input logic             hist_push_o,
  input logic             one_pend_o,
  input logic             buserr_o,
  input logic             ovf_o
);
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count_o <= CNT_W'(DEPTH));

  a_r2_full_push_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_full_o && push_i && !q_clear_i) |=> ovf_o);

  a_r2_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  a_r5_no_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_valid_o && !txen_pin_i && !txen_bit_i && !one_pend_o) |=> !buf_valid_o);

  a_r6_retry_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_valid_o && bus_lost_i && !one_shot_i && !abort_i && !bus_ok_i)
    |=> (buf_valid_o && $stable(buf_msg_o)));

  a_r7_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_valid_o && bus_err_i && !abort_i && !bus_ok_i) |=> buserr_o);

  a_r8_ok_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_push_o |=> !buf_valid_o);

  a_r9_abort_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_abort_o |=> !buf_valid_o);

  a_r9_abort_no_hist: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_abort_o |-> !hist_push_o);

  a_r11_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_valid_o |-> (!hist_push_o && !bus_abort_o));
endmodule

bind can_txq_sched can_txq_sched_chk #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .q_clear_i   (q_clear_i),
  .txen_pin_i  (txen_pin_i),
  .txen_bit_i  (txen_bit_i),
  .one_shot_i  (one_shot_i),
  .abort_i     (abort_i),
  .bus_ok_i    (bus_ok_i),
  .bus_lost_i  (bus_lost_i),
  .bus_err_i   (bus_err_i),
  .ovf_clr_i   (ovf_clr_i),
  .q_count_o   (q_count_o),
  .q_full_o    (q_full_o),
  .buf_valid_o (buf_valid_o),
  .buf_msg_o   (buf_msg_o),
  .bus_abort_o (bus_abort_o),
  .hist_push_o (hist_push_o),
  .one_pend_o  (one_pend_o),
  .buserr_o    (buserr_o),
  .ovf_o       (ovf_o)
);

// File: tb/can_txq_sched_tb_top.sv
`timescale 1ns/1ps
module can_txq_sched_tb_top;
  localparam int D = 8;
  localparam int W = 32;
  localparam int CW = $clog2(D+1);

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic rst_ni;
  logic push_i, q_clear_i, txen_pin_i, txen_bit_i, one_set_i, one_shot_i;
  logic abort_i, bus_ok_i, bus_lost_i, bus_err_i, err_ie_i, ovf_ie_i;
  logic buserr_clr_i, ovf_clr_i;
  logic [W-1:0] push_msg_i;
  logic [CW-1:0] q_count_o;
  logic q_full_o, buf_valid_o, bus_abort_o, hist_push_o, one_pend_o;
  logic buserr_o, ovf_o, irq_o;
  logic [W-1:0] buf_msg_o, hist_msg_o;

  can_txq_sched #(.DEPTH(D), .MSG_W(W)) dut_i (.*);

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [W-1:0] mq[$];
  bit m_bv, m_single, m_one, m_buserr, m_ovf;
  logic [W-1:0] m_msg;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clock();
    bit en, abort_hit, ok_hit, fail_hit, freed, load;
    int sz;
    en        = txen_pin_i | txen_bit_i;
    abort_hit = abort_i && m_bv;
    ok_hit    = bus_ok_i && m_bv && !abort_i;
    fail_hit  = (bus_lost_i || bus_err_i) && m_bv && !abort_i && !bus_ok_i;
    freed     = abort_hit || ok_hit || (fail_hit && one_shot_i);
    sz        = mq.size();
    load      = !m_bv && sz > 0 && (en || m_one) && !q_clear_i;
    if (fail_hit && bus_err_i) m_buserr = 1; else if (buserr_clr_i) m_buserr = 0;
    if (push_i && !q_clear_i && sz >= D) m_ovf = 1; else if (ovf_clr_i) m_ovf = 0;
    if (one_set_i) m_one = 1; else if (freed && m_single) m_one = 0;
    if (load) begin
      m_bv = 1; m_msg = mq.pop_front(); m_single = !en;
    end else if (freed) m_bv = 0;
    if (q_clear_i) mq.delete();
    else if (push_i && sz < D) mq.push_back(push_msg_i);
  endtask

  task automatic cmp_state();
    bit exp_irq;
    exp_irq = (m_buserr && err_ie_i) || (m_ovf && ovf_ie_i);
    chk("R1", "q_count", q_count_o, mq.size());
    chk("R2", "q_full", q_full_o, mq.size() == D);
    chk("R2", "ovf", ovf_o, m_ovf);
    chk("R3", "buf_valid", buf_valid_o, m_bv);
    if (m_bv) chk("R3", "buf_msg", buf_msg_o, m_msg);
    chk("R4", "one_pend", one_pend_o, m_one);
    chk("R7", "buserr", buserr_o, m_buserr);
    chk("R7", "irq", irq_o, exp_irq);
  endtask

  task automatic step();
    #1;
    chk("R9", "bus_abort", bus_abort_o, abort_i && m_bv);
    chk("R8", "hist_push", hist_push_o, bus_ok_i && m_bv && !abort_i);
    if (bus_ok_i && m_bv && !abort_i) chk("R8", "hist_msg", hist_msg_o, m_msg);
    @(posedge clk_i);
    model_clock();
    @(negedge clk_i);
    cmp_state();
    push_i = 0; q_clear_i = 0; one_set_i = 0; abort_i = 0;
    bus_ok_i = 0; bus_lost_i = 0; bus_err_i = 0; buserr_clr_i = 0; ovf_clr_i = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic push(logic [W-1:0] m);
    push_i = 1; push_msg_i = m; step();
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 0;
    push_i = 0; q_clear_i = 0; txen_pin_i = 0; txen_bit_i = 0; one_set_i = 0;
    one_shot_i = 0; abort_i = 0; bus_ok_i = 0; bus_lost_i = 0; bus_err_i = 0;
    err_ie_i = 0; ovf_ie_i = 0; buserr_clr_i = 0; ovf_clr_i = 0; push_msg_i = '0;
    m_bv = 0; m_single = 0; m_one = 0; m_buserr = 0; m_ovf = 0; m_msg = '0;
    repeat (3) @(negedge clk_i);
    cmp_state();                      // reset state, R1..R7 outputs
    rst_ni = 1;
    @(negedge clk_i);

    // R5: nothing loads while disabled
    push(32'hA000_0001); push(32'hA000_0002); push(32'hA000_0003);
    idle(2);
    chk("R5", "no load when disabled", buf_valid_o, 0);

    // R3: control bit enables automatic loading
    txen_bit_i = 1; step();
    chk("R3", "head loaded", buf_msg_o, 32'hA000_0001);
    bus_ok_i = 1; step();             // R8 success
    step();                           // next message loads
    txen_bit_i = 0;                   // R5 pause with frame in flight
    bus_lost_i = 1; step();
    chk("R6", "retry kept after lost", buf_valid_o, 1);
    err_ie_i = 1; bus_err_i = 1; step();
    chk("R7", "irq after error", irq_o, 1);
    chk("R6", "retry kept after error", buf_msg_o, 32'hA000_0002);
    bus_ok_i = 1; step();
    idle(2);
    chk("R5", "paused: no new load", buf_valid_o, 0);
    chk("R5", "paused: third still queued", q_count_o, 1);
    buserr_clr_i = 1; step();

    // R4: single send with enables low
    one_set_i = 1; step();
    step();
    chk("R4", "single message loaded", buf_msg_o, 32'hA000_0003);
    push(32'hB000_0001); push(32'hB000_0002);
    bus_ok_i = 1; step();
    idle(2);
    chk("R4", "single request cleared", one_pend_o, 0);
    chk("R4", "no second load", buf_valid_o, 0);

    // R6: one-shot discard, pin enable (R3)
    txen_pin_i = 1; one_shot_i = 1; step();
    bus_lost_i = 1; step();
    chk("R6", "one-shot discard", buf_valid_o, 0);
    step();
    chk("R6", "next loaded after discard", buf_msg_o, 32'hB000_0002);
    bus_err_i = 1; step();           // R7 error + discard
    txen_pin_i = 0; one_shot_i = 0;

    // R11: outcomes and abort with empty buffer
    buserr_clr_i = 1; step();
    bus_ok_i = 1; bus_err_i = 1; abort_i = 1; step();
    chk("R11", "idle outcomes ignored", buserr_o, 0);

    // R9: abort colliding with success
    push(32'hC000_0001);
    txen_pin_i = 1; step();
    abort_i = 1; bus_ok_i = 1; step();
    chk("R9", "aborted buffer freed", buf_valid_o, 0);
    txen_pin_i = 0;

    // R2 / R1: fill, overflow, drain in order
    ovf_ie_i = 1;
    for (int i = 0; i < D; i++) push(32'hD000_0000 + i);
    push(32'hDEAD_BEEF);
    chk("R2", "overflow flagged", ovf_o, 1);
    chk("R2", "overflow irq", irq_o, 1);
    ovf_clr_i = 1; step();
    txen_bit_i = 1;
    for (int i = 0; i < D; i++) begin
      step();
      chk("R1", "fifo order", buf_msg_o, 32'hD000_0000 + i);
      bus_ok_i = 1; step();
    end
    txen_bit_i = 0;

    // R10: clear wins over push and load
    push(32'hE000_0001); push(32'hE000_0002);
    txen_bit_i = 1; q_clear_i = 1; push_i = 1; push_msg_i = 32'hE000_0003; step();
    chk("R10", "clear beats push", q_count_o, 0);
    chk("R10", "clear beats load", buf_valid_o, 0);
    chk("R10", "no overflow from cleared push", ovf_o, 0);
    txen_bit_i = 0;
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule